// File: doc/BRIEF.md
# Cache Tag Directory with Hit, Miss and Eviction Counting

This block keeps the tag and valid state of a small cache that stores no data. Each request carries an operation code and a 10-bit byte address. A memory read or memory write is looked up in the set chosen by the address. A hit leaves the directory unchanged. A miss allocates a line in that set. An I/O write invalidates the whole directory in one step. An I/O read has no effect at all. Three saturating counters record hits, misses, and misses that displaced a valid line.

The directory holds `LINES` lines of 4-byte blocks. `WAYS` sets the organisation: 16 for fully associative, 4 for four-way, and 1 for direct mapped. On a miss the block first fills the lowest-numbered empty way of the set. Only when every way of the set is valid does it consult an external replacement selector. For that it raises `victim_need` together with `victim_set` and takes the way from `victim_way` in the same cycle.

Requests use valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while reset is asserted, so an upstream stage holding a request simply waits out reset. Once raised, a request must stay stable until it transfers. Each transfer produces exactly one `rsp_valid` pulse one cycle later. There is no response back-pressure.

Top module: `cache_tag_dir`

## Requirements
- R1: A synchronous reset clears every valid bit, drives `rsp_valid` low and sets the hit, miss and eviction counters to zero. The first memory access after reset therefore misses.
- R2: Bits [1:0] of the address are the block offset and never take part in the lookup. With `WAYS`=16 the tag is bits [9:2] and there is no set index. With `WAYS`=4 the set index is bits [3:2] and the tag is bits [9:4]. With `WAYS`=1 the set index is bits [5:2] and the tag is bits [9:6].
- R3: `req_ready` is high whenever reset is low. A transfer on edge t makes `rsp_valid` high for exactly the cycle after t. `rsp_valid` is low in every other cycle.
- R4: A memory read (op 0) or memory write (op 1) whose tag matches a valid line of its set returns `rsp_hit`=1 and increments the hit counter. The directory does not change.
- R5: A memory read or write that finds no match returns `rsp_hit`=0, increments the miss counter and allocates the line. A later access to the same block then hits.
- R6: On a miss to a set with an empty way, the lowest-numbered empty way is filled. `victim_need` stays low, `victim_way` is ignored and the eviction counter is unchanged.
- R7: On a miss to a set whose ways are all valid, `victim_need` is high in the request cycle. The way given on `victim_way` is overwritten, so its old tag misses afterwards, and the eviction counter increments.
- R8: An I/O write (op 3) invalidates every line, returns `rsp_hit`=0 and changes no counter.
- R9: An I/O read (op 2) returns `rsp_hit`=0 and changes neither the directory nor any counter.
- R10: Each counter is `CNT_W` bits wide (32 by default) and holds at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_op | input | 2 | 0 memory read, 1 memory write, 2 I/O read, 3 I/O write |
| req_addr | input | ADDR_W (10) | Byte address |
| victim_need | output | 1 | Current request misses in a full set |
| victim_set | output | SET_IW | Set index of the current request |
| victim_way | input | WAY_W | Way to replace, sampled when `victim_need` is high |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response was a memory hit |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |
| evict_cnt | output | CNT_W | Saturating count of valid lines displaced |

## Verification
`rsp_valid`, `rsp_hit` and all three counters are registered. Each becomes due in the first cycle after the edge on which the request transferred. `victim_need` is combinational and is due in the request cycle itself, before that edge. The bench drives inputs on falling edges. Its reference model updates on the rising edge from those inputs, and the registered results are compared on the next falling edge. `victim_need` is sampled one time step after the inputs are driven, while the request is still being offered.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;
  typedef enum logic [1:0] {
    OP_MEM_RD = 2'd0,
    OP_MEM_WR = 2'd1,
    OP_IO_RD  = 2'd2,
    OP_IO_WR  = 2'd3
  } dir_op_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cdir_addr_split.sv
module cdir_addr_split #(
  parameter int ADDR_W = 10,
  parameter int OFFS_W = 2,
  parameter int SET_W  = 2,
  parameter int SET_IW = 2,
  parameter int TAG_W  = 6
) (
  input  logic [ADDR_W-1:OFFS_W] blk_addr,
  output logic [SET_IW-1:0]      set_idx,
  output logic [TAG_W-1:0]       tag
);
  generate
    if (SET_W == 0) begin : g_noidx
      assign set_idx = '0;
    end else begin : g_idx
      assign set_idx = blk_addr[OFFS_W +: SET_W];
    end
  endgenerate

  assign tag = blk_addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cdir_tag_array.sv
module cdir_tag_array #(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int SET_IW = 2,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_IW-1:0] lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_full,
  output logic [WAY_W-1:0]  free_way,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              flush
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  set_valid;
  logic             any_valid;

  assign set_valid = valid_q[lk_set];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = set_valid[w] && (tag_q[lk_set][w] == lk_tag);
    end
  endgenerate

  assign lk_hit  = |match;
  assign lk_full = &set_valid;

  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_valid[i]) free_way = WAY_W'(i);
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[lk_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst) tag_q[lk_set][wr_way] <= lk_tag;
  end

  // R4: a tag never sits valid in two ways of one set
  assert_single_match_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R8: a flush leaves nothing valid
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_valid);

  // R5: a fill makes the looked-up set non-empty
  assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> any_valid);
endmodule

// File: rtl/cdir_sat_cnt.sv
module cdir_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                   q <= '0;
    else if (inc && (q != '1)) q <= q + 1'b1;
  end

  // R10: a full counter stays full
  assert_hold_at_max_R10: assert property (@(posedge clk) disable iff (rst)
    (q == '1) |=> (q == '1));

  // R10: never moves without an increment
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(q));
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import cache_dir_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFFS_W = 2,
  parameter int LINES  = 16,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 32,
  localparam int SETS   = LINES / WAYS,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 0,
  localparam int SET_IW = idx_width(SETS),
  localparam int WAY_W  = idx_width(WAYS),
  localparam int TAG_W  = ADDR_W - OFFS_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              victim_need,
  output logic [SET_IW-1:0] victim_set,
  input  logic [WAY_W-1:0]  victim_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [CNT_W-1:0]  evict_cnt
);
  logic [SET_IW-1:0] set_idx;
  logic [TAG_W-1:0]  tag;
  logic              lk_hit, lk_full;
  logic [WAY_W-1:0]  free_way, fill_way;
  logic              accept, is_mem, mem_hit, mem_miss, do_evict, do_flush;
  dir_op_e           op;

  assign op        = dir_op_e'(req_op);
  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;
  assign is_mem    = accept && (op == OP_MEM_RD || op == OP_MEM_WR);
  assign mem_hit   = is_mem && lk_hit;
  assign mem_miss  = is_mem && !lk_hit;
  assign do_evict  = mem_miss && lk_full;
  assign do_flush  = accept && (op == OP_IO_WR);

  cdir_addr_split #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SET_W(SET_W),
    .SET_IW(SET_IW), .TAG_W(TAG_W)
  ) u_split (
    .blk_addr (req_addr[ADDR_W-1:OFFS_W]),
    .set_idx  (set_idx),
    .tag      (tag)
  );

  generate
    if (WAYS == 1) begin : g_dm
      assign fill_way = '0;
    end else begin : g_assoc
      assign fill_way = lk_full ? victim_way : free_way;
    end
  endgenerate

  cdir_tag_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W),
    .SET_IW(SET_IW), .WAY_W(WAY_W)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .lk_set   (set_idx),
    .lk_tag   (tag),
    .lk_hit   (lk_hit),
    .lk_full  (lk_full),
    .free_way (free_way),
    .wr_en    (mem_miss),
    .wr_way   (fill_way),
    .flush    (do_flush)
  );

  assign victim_need = do_evict;
  assign victim_set  = set_idx;

  cdir_sat_cnt #(.W(CNT_W)) u_hits  (.clk(clk), .rst(rst), .inc(mem_hit),  .q(hit_cnt));
  cdir_sat_cnt #(.W(CNT_W)) u_miss  (.clk(clk), .rst(rst), .inc(mem_miss), .q(miss_cnt));
  cdir_sat_cnt #(.W(CNT_W)) u_evict (.clk(clk), .rst(rst), .inc(do_evict), .q(evict_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= mem_hit;
    end
  end

  // R3: one response pulse per transfer, nothing else
  assert_rsp_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);

  // R9: an I/O read leaves all counters alone
  assert_ioread_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_IO_RD) |=> ($stable(hit_cnt) && $stable(miss_cnt) && $stable(evict_cnt)));

  // R8: an I/O write leaves all counters alone
  assert_iowrite_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_IO_WR) |=> ($stable(hit_cnt) && $stable(miss_cnt) && $stable(evict_cnt)));

  // R7: an eviction is always counted together with a miss
  assert_evict_is_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (evict_cnt != $past(evict_cnt)) |-> ((miss_cnt != $past(miss_cnt)) || (miss_cnt == '1)));

  // R4: a hit response never comes with a miss count step
  assert_hit_not_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> ($stable(miss_cnt) && $stable(evict_cnt)));
endmodule

// File: tb/tb_cache_tag_dir.sv
module tb_cache_tag_dir;
  localparam int CW  = 6;
  localparam int MAX = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [9:0] req_addr = '0;
  logic       victim_need;
  logic [1:0] victim_set;
  logic [1:0] victim_way = 2'd0;
  logic       rsp_valid, rsp_hit;
  logic [CW-1:0] hit_cnt, miss_cnt, evict_cnt;

  int checks = 0;
  int failures = 0;
  logic last_vneed;

  always #5 clk = ~clk;

  cache_tag_dir #(.WAYS(4), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .victim_need(victim_need),
    .victim_set(victim_set), .victim_way(victim_way), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .evict_cnt(evict_cnt)
  );

  // Behavioural reference: 4 sets x 4 ways, address split per R2
  bit mv [4][4];
  int mt [4][4];
  int m_hits = 0, m_miss = 0, m_evict = 0;
  bit m_rv = 0, m_rh = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
      m_hits = 0; m_miss = 0; m_evict = 0; m_rv = 0; m_rh = 0;
    end else begin
      m_rv = req_valid;
      m_rh = 0;
      if (req_valid) begin
        if (req_op <= 2'd1) begin
          int s, t, hw, fw;
          s = (int'(req_addr) >> 2) & 3;
          t = int'(req_addr) >> 4;
          hw = -1;
          for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
          if (hw >= 0) begin
            m_rh = 1;
            if (m_hits < MAX) m_hits++;
          end else begin
            if (m_miss < MAX) m_miss++;
            fw = -1;
            for (int w = 3; w >= 0; w--) if (!mv[s][w]) fw = w;
            if (fw < 0) begin
              fw = int'(victim_way);
              if (m_evict < MAX) m_evict++;
            end
            mv[s][fw] = 1;
            mt[s][fw] = t;
          end
        end else if (req_op == 2'd3) begin
          for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 req_ready", int'(req_ready), 1);
      chk("R3 rsp_valid", int'(rsp_valid), int'(m_rv));
      if (rsp_valid) chk("R4/R5 rsp_hit", int'(rsp_hit), int'(m_rh));
      chk("R4/R10 hit_cnt", int'(hit_cnt), m_hits);
      chk("R5/R10 miss_cnt", int'(miss_cnt), m_miss);
      chk("R7/R10 evict_cnt", int'(evict_cnt), m_evict);
    end
  end

  // Called on a falling edge; returns on the next falling edge
  task automatic send(input logic [1:0] op, input int tag, input int set,
                      input int off, input int vway);
    req_valid  = 1'b1;
    req_op     = op;
    req_addr   = 10'((tag << 4) | (set << 2) | off);
    victim_way = 2'(vway);
    #1 last_vneed = victim_need;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 hit_cnt after reset", int'(hit_cnt), 0);
    chk("R1 miss_cnt after reset", int'(miss_cnt), 0);
    chk("R1 evict_cnt after reset", int'(evict_cnt), 0);

    // R6: fill set 0 with tags 0..3, empty ways, no victim use
    for (int t = 0; t < 4; t++) begin
      send(2'd0, t, 0, 0, 3);
      chk("R6 victim_need on empty fill", int'(last_vneed), 0);
      chk("R1/R5 first access misses", int'(rsp_hit), 0);
    end
    chk("R6 no eviction on empty fills", int'(evict_cnt), 0);
    // R2/R4: same blocks, different offset -> hits
    for (int t = 0; t < 4; t++) begin
      send(2'd0, t, 0, 3, 0);
      chk("R2 offset ignored, hit", int'(rsp_hit), 1);
    end
    chk("R4 hit_cnt", int'(hit_cnt), 4);
    // R2: same tag, other set -> miss, no eviction
    send(2'd0, 0, 1, 0, 0);
    chk("R2 set index separates", int'(rsp_hit), 0);
    // R7/R5: write miss into full set 0, replace way 2 (tag 2)
    send(2'd1, 4, 0, 0, 2);
    chk("R7 victim_need full set", int'(last_vneed), 1);
    chk("R7 evict_cnt", int'(evict_cnt), 1);
    send(2'd0, 4, 0, 1, 0);
    chk("R5 write miss allocated", int'(rsp_hit), 1);
    send(2'd0, 2, 0, 0, 0);
    chk("R7 replaced tag misses", int'(rsp_hit), 0);
    chk("R7 evict_cnt second", int'(evict_cnt), 2);
    // R9: I/O read changes nothing
    send(2'd2, 4, 0, 0, 0);
    chk("R9 io read rsp_hit", int'(rsp_hit), 0);
    send(2'd0, 4, 0, 0, 0);
    chk("R9 state kept after io read", int'(rsp_hit), 1);
    // R8: I/O write flushes without eviction
    send(2'd3, 0, 0, 0, 0);
    chk("R8 io write rsp_hit", int'(rsp_hit), 0);
    chk("R8 evict_cnt unchanged", int'(evict_cnt), 2);
    send(2'd0, 4, 0, 0, 1);
    chk("R8 flushed line misses", int'(rsp_hit), 0);
    chk("R8 refill not an eviction", int'(evict_cnt), 2);

    // Mixed random traffic with idle gaps, compared every cycle
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 4) == 0) @(negedge clk);
      else send(2'((($urandom % 16) == 0) ? 3 : ($urandom % 3)),
                int'($urandom % 8), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % 4));
    end
    @(negedge clk);
    // R10: hit count saturates at its maximum
    chk("R10 hit_cnt saturated", int'(hit_cnt), MAX);
    finish_run();
  end
endmodule